// File: doc/BRIEF.md
# Arithmetic Unit with Status Flags

This block is the integer arithmetic stage of a small processor core together with the flag word that stores its condition bits. Each cycle it can accept one operation on two operands, in byte or word width. The operation is one of add, add with carry, subtract, subtract with borrow, AND, OR, XOR, increment or decrement. One clock edge later the block presents the registered result and the updated condition bits. Add with carry and subtract with borrow take their carry or borrow input from the stored carry bit.

A separate command input sets or clears the three control bits: the string direction, the maskable interrupt enable and single-step. Software can also load the whole flag word at once. Status bits and control bits are written through independent paths, so an arithmetic operation and a control command in the same cycle both take effect. A whole-word load in the same cycle overrides both.

Top module: `alu_flags`

## Requirements
- R1: While reset (active low, asynchronous) is held and after its release, `flags` reads 16'hF002, `result` reads 0 and `res_done` is 0.
- R2: The flag word places carry at bit 0, parity at 2, auxiliary carry at 4, zero at 6, sign at 7, single-step at 8, interrupt enable at 9, direction at 10 and overflow at 11. Bit 1 and bits 15:12 always read 1, and bits 3 and 5 always read 0, whatever is written.
- R3: Operation codes are ADD=0, ADC=1, SUB=2, SBB=3, AND=4, OR=5, XOR=6, INC=7, DEC=8. With `op_valid` high in cycle N, `result` and the flags show the outcome after the edge that ends cycle N, and `res_done` is high for that one cycle. In byte mode (`is_word`=0) only the low bytes are used and the high byte of `result` is 0.
- R4: Carry is set on a carry out of, or a borrow into, the top bit of the selected width (bit 7 or bit 15). ADC adds the stored carry and SBB subtracts it.
- R5: Overflow is set when the signed result does not fit the selected width.
- R6: Sign equals the top bit of the result for the selected width. Zero is set when the result is all zeros.
- R7: Auxiliary carry is set on a carry out of, or a borrow into, bit 3.
- R8: Parity is set when the low byte of the result holds an even number of 1 bits, in both widths.
- R9: AND, OR and XOR clear carry, overflow and auxiliary carry.
- R10: INC and DEC update every status bit except carry, which keeps its value.
- R11: `ctl_cmd` codes: 0 none, 1 clear direction, 2 set direction, 3 clear interrupt enable, 4 set interrupt enable, 5 clear single-step, 6 set single-step, 7 none. The change is visible after one edge, and status bits are not affected.
- R12: With `flag_wr` high, the nine flag bits take their values from `flag_wdata` after the edge. The load wins over an operation and a command in the same cycle, but the operation's `result` and `res_done` still appear.
- R13: Operation codes 9 to 15 with `op_valid` high leave `result` and all flags unchanged and do not raise `res_done`.
- R14: An operation and a control command in the same cycle both take effect: the status bits come from the operation and the control bit from the command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| op_valid | input | 1 | Start an operation this cycle |
| op_code | input | 4 | Operation select |
| is_word | input | 1 | 1 for word width, 0 for byte width |
| opnd_a | input | 16 | First operand (minuend) |
| opnd_b | input | 16 | Second operand (subtrahend) |
| ctl_cmd | input | 3 | Control flag set/clear command |
| flag_wr | input | 1 | Load the whole flag word |
| flag_wdata | input | 16 | Flag word to load |
| result | output | 16 | Registered result |
| res_done | output | 1 | One-cycle pulse when `result` is new |
| flags | output | 16 | Flag word |

## Verification
Three pairs of functions can fall on the same clock edge: an operation and a control command, an operation and a whole-word load, and a command and a load. The bench drives each pair in a single cycle. For operation plus command, it checks that the status bits match the arithmetic and that the commanded control bit also changed (R14). For a load together with an operation or a command, it checks that the flag word equals the loaded value while `result` and `res_done` still reflect the operation (R12). Every cycle's expected flag word is derived from a bench-side model of the requirements and compared one edge later.

// File: rtl/alu_flags_pkg.sv
package alu_flags_pkg;

    localparam int FLAG_W = 16;

    // operation codes
    localparam logic [3:0] OP_ADD = 4'd0;
    localparam logic [3:0] OP_ADC = 4'd1;
    localparam logic [3:0] OP_SUB = 4'd2;
    localparam logic [3:0] OP_SBB = 4'd3;
    localparam logic [3:0] OP_AND = 4'd4;
    localparam logic [3:0] OP_OR  = 4'd5;
    localparam logic [3:0] OP_XOR = 4'd6;
    localparam logic [3:0] OP_INC = 4'd7;
    localparam logic [3:0] OP_DEC = 4'd8;

    // control commands
    localparam logic [2:0] CC_NONE   = 3'd0;
    localparam logic [2:0] CC_DIR_0  = 3'd1;
    localparam logic [2:0] CC_DIR_1  = 3'd2;
    localparam logic [2:0] CC_IEN_0  = 3'd3;
    localparam logic [2:0] CC_IEN_1  = 3'd4;
    localparam logic [2:0] CC_STEP_0 = 3'd5;
    localparam logic [2:0] CC_STEP_1 = 3'd6;

    // flag word bit positions
    localparam int FB_CF = 0;
    localparam int FB_PF = 2;
    localparam int FB_AF = 4;
    localparam int FB_ZF = 6;
    localparam int FB_SF = 7;
    localparam int FB_TF = 8;
    localparam int FB_IF = 9;
    localparam int FB_DF = 10;
    localparam int FB_OF = 11;

    localparam logic [FLAG_W-1:0] FIXED_ONES = 16'hF002;
    localparam logic [FLAG_W-1:0] LIVE_MASK  = 16'h0FD5;

    typedef struct packed {
        logic ov;
        logic sg;
        logic zr;
        logic ax;
        logic pa;
        logic cy;
    } status_t;

    typedef struct packed {
        logic ov;
        logic dir;
        logic ien;
        logic step;
        logic sg;
        logic zr;
        logic ax;
        logic pa;
        logic cy;
    } flagset_t;

endpackage

// File: rtl/alu_parity.sv
module alu_parity #(
    parameter int W = 8
) (
    input  logic [W-1:0] bits_i,
    output logic         even_o
);
    assign even_o = ~(^bits_i);
endmodule

// File: rtl/alu_datapath.sv
module alu_datapath
    import alu_flags_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int LOW_W  = 8
) (
    input  logic [3:0]        op_i,
    input  logic              word_i,
    input  logic [DATA_W-1:0] a_i,
    input  logic [DATA_W-1:0] b_i,
    input  logic              cf_i,
    output logic [DATA_W-1:0] res_o,
    output status_t           st_o,
    output logic              known_o,
    output logic              keep_cf_o
);
    localparam int EXT_W = DATA_W + 1;
    localparam int HI_W  = DATA_W - LOW_W;

    logic              is_incdec, is_sub, is_logic, use_cin;
    logic [DATA_W-1:0] a_m, b_src, b_m, raw_logic, xv;
    logic [EXT_W-1:0]  sum_x, dif_x, arith_x;
    logic [DATA_W-1:0] res_d;
    logic              top_a, top_b, top_r, ovf_d, cy_d;
    logic              par_even;

    always_comb begin
        known_o   = (op_i <= OP_DEC);
        is_incdec = (op_i == OP_INC) || (op_i == OP_DEC);
        is_sub    = (op_i == OP_SUB) || (op_i == OP_SBB) || (op_i == OP_DEC);
        is_logic  = (op_i == OP_AND) || (op_i == OP_OR) || (op_i == OP_XOR);
        use_cin   = (op_i == OP_ADC) || (op_i == OP_SBB);
        keep_cf_o = is_incdec;

        b_src = is_incdec ? DATA_W'(1) : b_i;
        a_m   = word_i ? a_i   : {{HI_W{1'b0}}, a_i[LOW_W-1:0]};
        b_m   = word_i ? b_src : {{HI_W{1'b0}}, b_src[LOW_W-1:0]};

        sum_x   = {1'b0, a_m} + {1'b0, b_m} + EXT_W'(use_cin & cf_i);
        dif_x   = {1'b0, a_m} - {1'b0, b_m} - EXT_W'(use_cin & cf_i);
        arith_x = is_sub ? dif_x : sum_x;

        case (op_i)
            OP_AND:  raw_logic = a_m & b_m;
            OP_OR:   raw_logic = a_m | b_m;
            default: raw_logic = a_m ^ b_m;
        endcase

        res_d = is_logic ? raw_logic : arith_x[DATA_W-1:0];
        if (!word_i) res_d[DATA_W-1:LOW_W] = '0;

        top_a = word_i ? a_m[DATA_W-1]   : a_m[LOW_W-1];
        top_b = word_i ? b_m[DATA_W-1]   : b_m[LOW_W-1];
        top_r = word_i ? res_d[DATA_W-1] : res_d[LOW_W-1];
        cy_d  = word_i ? arith_x[DATA_W] : arith_x[LOW_W];

        if (is_sub) ovf_d = (top_a != top_b) && (top_r != top_a);
        else        ovf_d = (top_a == top_b) && (top_r != top_a);

        xv = a_m ^ b_m ^ res_d;
    end

    alu_parity #(.W(LOW_W)) u_par (
        .bits_i (res_d[LOW_W-1:0]),
        .even_o (par_even)
    );

    always_comb begin
        res_o    = res_d;
        st_o.sg  = top_r;
        st_o.zr  = (res_d == '0);
        st_o.pa  = par_even;
        st_o.ov  = is_logic ? 1'b0 : ovf_d;
        st_o.cy  = is_logic ? 1'b0 : cy_d;
        st_o.ax  = is_logic ? 1'b0 : xv[4];
    end

endmodule

// File: rtl/alu_flag_store.sv
module alu_flag_store
    import alu_flags_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              st_en_i,
    input  logic              cf_en_i,
    input  status_t           st_i,
    input  logic [2:0]        cmd_i,
    input  logic              wr_en_i,
    input  logic [FLAG_W-1:0] wr_data_i,
    output logic [FLAG_W-1:0] flags_o,
    output logic              cf_o
);
    flagset_t fl_d, fl_q;

    always_comb begin
        fl_d = fl_q;
        // status path
        if (st_en_i) begin
            fl_d.ov = st_i.ov;
            fl_d.sg = st_i.sg;
            fl_d.zr = st_i.zr;
            fl_d.ax = st_i.ax;
            fl_d.pa = st_i.pa;
        end
        if (cf_en_i) fl_d.cy = st_i.cy;
        // control path
        case (cmd_i)
            CC_DIR_0:  fl_d.dir  = 1'b0;
            CC_DIR_1:  fl_d.dir  = 1'b1;
            CC_IEN_0:  fl_d.ien  = 1'b0;
            CC_IEN_1:  fl_d.ien  = 1'b1;
            CC_STEP_0: fl_d.step = 1'b0;
            CC_STEP_1: fl_d.step = 1'b1;
            default:   ;
        endcase
        // whole-word load overrides both paths
        if (wr_en_i) begin
            fl_d.cy   = wr_data_i[FB_CF];
            fl_d.pa   = wr_data_i[FB_PF];
            fl_d.ax   = wr_data_i[FB_AF];
            fl_d.zr   = wr_data_i[FB_ZF];
            fl_d.sg   = wr_data_i[FB_SF];
            fl_d.step = wr_data_i[FB_TF];
            fl_d.ien  = wr_data_i[FB_IF];
            fl_d.dir  = wr_data_i[FB_DF];
            fl_d.ov   = wr_data_i[FB_OF];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) fl_q <= '0;
        else        fl_q <= fl_d;
    end

    always_comb begin
        flags_o        = FIXED_ONES;
        flags_o[FB_CF] = fl_q.cy;
        flags_o[FB_PF] = fl_q.pa;
        flags_o[FB_AF] = fl_q.ax;
        flags_o[FB_ZF] = fl_q.zr;
        flags_o[FB_SF] = fl_q.sg;
        flags_o[FB_TF] = fl_q.step;
        flags_o[FB_IF] = fl_q.ien;
        flags_o[FB_DF] = fl_q.dir;
        flags_o[FB_OF] = fl_q.ov;
        cf_o           = fl_q.cy;
    end

    p_load_word_r12: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en_i |=> ((flags_o & LIVE_MASK) == ($past(wr_data_i) & LIVE_MASK)));

    p_set_dir_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_i == CC_DIR_1 && !wr_en_i) |=> flags_o[FB_DF]);

    p_ctl_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        ((cmd_i == CC_NONE || cmd_i == 3'd7) && !wr_en_i) |=> $stable(flags_o[FB_DF:FB_TF]));

endmodule

// File: rtl/alu_flags.sv
module alu_flags
    import alu_flags_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int LOW_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              op_valid,
    input  logic [3:0]        op_code,
    input  logic              is_word,
    input  logic [DATA_W-1:0] opnd_a,
    input  logic [DATA_W-1:0] opnd_b,
    input  logic [2:0]        ctl_cmd,
    input  logic              flag_wr,
    input  logic [15:0]       flag_wdata,
    output logic [DATA_W-1:0] result,
    output logic              res_done,
    output logic [15:0]       flags
);
    typedef struct packed {
        logic [DATA_W-1:0] res;
        logic              done;
    } out_t;

    out_t              out_d, out_q;
    logic [DATA_W-1:0] dp_res;
    status_t           dp_st;
    logic              dp_known, dp_keep_cf, cf_now;
    logic              st_en, cf_en;

    alu_datapath #(.DATA_W(DATA_W), .LOW_W(LOW_W)) u_dp (
        .op_i      (op_code),
        .word_i    (is_word),
        .a_i       (opnd_a),
        .b_i       (opnd_b),
        .cf_i      (cf_now),
        .res_o     (dp_res),
        .st_o      (dp_st),
        .known_o   (dp_known),
        .keep_cf_o (dp_keep_cf)
    );

    always_comb begin
        st_en = op_valid && dp_known;
        cf_en = st_en && !dp_keep_cf;
        out_d      = out_q;
        out_d.done = st_en;
        if (st_en) out_d.res = dp_res;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) out_q <= '0;
        else        out_q <= out_d;
    end

    alu_flag_store u_fs (
        .clk       (clk),
        .rst_n     (rst_n),
        .st_en_i   (st_en),
        .cf_en_i   (cf_en),
        .st_i      (dp_st),
        .cmd_i     (ctl_cmd),
        .wr_en_i   (flag_wr),
        .wr_data_i (flag_wdata),
        .flags_o   (flags),
        .cf_o      (cf_now)
    );

    assign result   = out_q.res;
    assign res_done = out_q.done;

    p_logic_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && !flag_wr && (op_code == OP_AND || op_code == OP_OR || op_code == OP_XOR))
        |=> (!flags[FB_CF] && !flags[FB_OF] && !flags[FB_AF]));

    p_incdec_keep_cf_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && !flag_wr && (op_code == OP_INC || op_code == OP_DEC))
        |=> (flags[FB_CF] == $past(flags[FB_CF])));

    p_zero_flag_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && (op_code <= OP_DEC) && !flag_wr) |=> (flags[FB_ZF] == (result == '0)));

    p_sign_flag_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && (op_code <= OP_DEC) && !flag_wr)
        |=> (flags[FB_SF] == ($past(is_word) ? result[DATA_W-1] : result[LOW_W-1])));

    p_parity_low_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && (op_code <= OP_DEC) && !flag_wr) |=> (flags[FB_PF] == ~(^result[LOW_W-1:0])));

    p_reserved_hold_r13: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && (op_code > OP_DEC) && !flag_wr && ctl_cmd == CC_NONE)
        |=> ($stable(flags) && $stable(result) && !res_done));

    p_done_pulse_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && (op_code <= OP_DEC)) |=> res_done);

endmodule

// File: tb/sim_alu_flags.sv
`timescale 1ns/1ps
module sim_alu_flags;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        op_valid = 1'b0;
    logic [3:0]  op_code = '0;
    logic        is_word = 1'b0;
    logic [15:0] opnd_a = '0;
    logic [15:0] opnd_b = '0;
    logic [2:0]  ctl_cmd = '0;
    logic        flag_wr = 1'b0;
    logic [15:0] flag_wdata = '0;
    logic [15:0] result;
    logic        res_done;
    logic [15:0] flags;

    int n_run = 0;
    int n_fail = 0;

    typedef struct {
        logic [15:0] res;
        logic        done;
        logic [15:0] fl;
        string       tag;
    } exp_t;

    exp_t        sb[$];
    logic [15:0] m_fl  = 16'hF002;
    logic [15:0] m_res = 16'h0000;

    always #5 clk = ~clk;

    alu_flags u0 (
        .clk        (clk),
        .rst_n      (rst_n),
        .op_valid   (op_valid),
        .op_code    (op_code),
        .is_word    (is_word),
        .opnd_a     (opnd_a),
        .opnd_b     (opnd_b),
        .ctl_cmd    (ctl_cmd),
        .flag_wr    (flag_wr),
        .flag_wdata (flag_wdata),
        .result     (result),
        .res_done   (res_done),
        .flags      (flags)
    );

    // driver: one call per cycle, pushes expected outcome of that cycle
    task automatic step(input logic v, input logic [3:0] op, input logic w,
                        input logic [15:0] a, input logic [15:0] b,
                        input logic [2:0] cmd, input logic wr,
                        input logic [15:0] wd, input string tag);
        exp_t e;
        int   width, msk, top, bb, cin, full, r;
        logic done;
        @(negedge clk);
        op_valid = v; op_code = op; is_word = w; opnd_a = a; opnd_b = b;
        ctl_cmd = cmd; flag_wr = wr; flag_wdata = wd;
        done = v && (op <= 4'd8);
        if (done) begin
            width = w ? 16 : 8;
            msk   = (1 << width) - 1;
            top   = 1 << (width - 1);
            bb    = (op == 4'd7 || op == 4'd8) ? 1 : int'(b) & msk;
            cin   = (op == 4'd1 || op == 4'd3) ? int'(m_fl[0]) : 0;
            if (op == 4'd0 || op == 4'd1 || op == 4'd7) begin
                full = (int'(a) & msk) + bb + cin;
                r = full & msk;
                if (op != 4'd7) m_fl[0] = (full > msk);
                m_fl[11] = (((int'(a) ^ r) & (bb ^ r) & top) != 0);
                m_fl[4]  = (((int'(a) ^ bb ^ r) & 16) != 0);
            end else if (op == 4'd2 || op == 4'd3 || op == 4'd8) begin
                full = (int'(a) & msk) - bb - cin;
                r = full & msk;
                if (op != 4'd8) m_fl[0] = (full < 0);
                m_fl[11] = (((int'(a) ^ bb) & (int'(a) ^ r) & top) != 0);
                m_fl[4]  = (((int'(a) ^ bb ^ r) & 16) != 0);
            end else begin
                if (op == 4'd4)      r = int'(a) & int'(b) & msk;
                else if (op == 4'd5) r = (int'(a) | int'(b)) & msk;
                else                 r = (int'(a) ^ int'(b)) & msk;
                m_fl[0] = 1'b0; m_fl[11] = 1'b0; m_fl[4] = 1'b0;
            end
            m_fl[7] = ((r & top) != 0);
            m_fl[6] = (r == 0);
            m_fl[2] = ($countones(r & 255) % 2) == 0;
            m_res   = 16'(r);
        end
        case (cmd)
            3'd1: m_fl[10] = 1'b0;
            3'd2: m_fl[10] = 1'b1;
            3'd3: m_fl[9]  = 1'b0;
            3'd4: m_fl[9]  = 1'b1;
            3'd5: m_fl[8]  = 1'b0;
            3'd6: m_fl[8]  = 1'b1;
            default: ;
        endcase
        if (wr) m_fl = (wd & 16'h0FD5) | 16'hF002;
        e.res = m_res; e.done = done; e.fl = m_fl; e.tag = tag;
        sb.push_back(e);
    endtask

    task automatic idle(input string tag);
        step(1'b0, 4'd0, 1'b0, 16'h0, 16'h0, 3'd0, 1'b0, 16'h0, tag);
    endtask

    // monitor: compares after every edge that follows a driven cycle
    always begin
        exp_t e;
        @(posedge clk);
        #2;
        if (sb.size() > 0) begin
            e = sb.pop_front();
            n_run++;
            if (result !== e.res || res_done !== e.done || flags !== e.fl) begin
                n_fail++;
                $display("FAIL %s: result=%h done=%b flags=%h expected result=%h done=%b flags=%h",
                         e.tag, result, res_done, flags, e.res, e.done, e.fl);
            end
        end
    end

    initial begin
        #200000;
        n_fail++;
        $display("FAIL watchdog: actual=hung expected=finished");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        n_run++;
        if (flags !== 16'hF002 || result !== 16'h0 || res_done !== 1'b0) begin
            n_fail++;
            $display("FAIL R1: flags=%h result=%h done=%b expected flags=f002 result=0000 done=0",
                     flags, result, res_done);
        end
        rst_n = 1'b1;
        idle("R1 after release");

        // R3 R5 R6 R7: byte add crossing into sign bit
        step(1, 4'd0, 0, 16'h007F, 16'h0001, 3'd0, 0, 0, "R5 byte add overflow");
        // R4 R6 R8: word add wrapping to zero
        step(1, 4'd0, 1, 16'hFFFF, 16'h0001, 3'd0, 0, 0, "R4 word add carry");
        // R4: ADC consumes carry
        step(1, 4'd1, 1, 16'h1234, 16'h0001, 3'd0, 0, 0, "R4 adc carry in");
        // R4 borrow, byte
        step(1, 4'd2, 0, 16'h0000, 16'h0001, 3'd0, 0, 0, "R4 byte sub borrow");
        step(1, 4'd3, 0, 16'h0010, 16'h0001, 3'd0, 0, 0, "R4 sbb borrow in");
        // R5 signed sub overflow, word
        step(1, 4'd2, 1, 16'h8000, 16'h0001, 3'd0, 0, 0, "R5 word sub overflow");
        // R3 byte mode drops the high bytes
        step(1, 4'd0, 0, 16'hAB10, 16'hCD20, 3'd0, 0, 0, "R3 byte high ignored");
        // R8 parity from low byte only
        step(1, 4'd5, 1, 16'h0300, 16'h0001, 3'd0, 0, 0, "R8 parity low byte");
        // R9 logic clears carry/overflow/aux after a setting op
        step(1, 4'd0, 1, 16'hFFFF, 16'hFFFF, 3'd0, 0, 0, "R4 setup carry");
        step(1, 4'd4, 1, 16'hF0F0, 16'h0FF0, 3'd0, 0, 0, "R9 and clears");
        step(1, 4'd6, 0, 16'h00AA, 16'h00AA, 3'd0, 0, 0, "R9 xor zero");
        // R10 inc/dec keep carry
        step(1, 4'd0, 0, 16'h00FF, 16'h0001, 3'd0, 0, 0, "R4 setup carry byte");
        step(1, 4'd7, 0, 16'h007F, 16'h0000, 3'd0, 0, 0, "R10 inc keeps carry");
        step(1, 4'd8, 1, 16'h0000, 16'h0000, 3'd0, 0, 0, "R10 dec keeps carry");
        step(1, 4'd8, 1, 16'h8000, 16'h0000, 3'd0, 0, 0, "R7 dec overflow aux");
        // R13 reserved codes
        step(1, 4'd9,  1, 16'h1111, 16'h2222, 3'd0, 0, 0, "R13 reserved 9");
        step(1, 4'd15, 0, 16'h0000, 16'h0000, 3'd0, 0, 0, "R13 reserved 15");
        // R11 control commands
        step(0, 0, 0, 0, 0, 3'd2, 0, 0, "R11 set dir");
        step(0, 0, 0, 0, 0, 3'd4, 0, 0, "R11 set ien");
        step(0, 0, 0, 0, 0, 3'd6, 0, 0, "R11 set step");
        step(0, 0, 0, 0, 0, 3'd7, 0, 0, "R11 code 7 none");
        step(0, 0, 0, 0, 0, 3'd3, 0, 0, "R11 clear ien");
        // R14 op and command together
        step(1, 4'd2, 1, 16'h0005, 16'h0005, 3'd1, 0, 0, "R14 op with clear dir");
        step(1, 4'd0, 0, 16'h0080, 16'h0080, 3'd5, 0, 0, "R14 op with clear step");
        // R12 whole word load, with op and command in same cycle; R2 fixed bits
        step(0, 0, 0, 0, 0, 3'd0, 1, 16'h0000, "R2 fixed bits on load");
        step(1, 4'd0, 1, 16'hFFFF, 16'h0001, 3'd2, 1, 16'h0A55, "R12 load wins");
        step(0, 0, 0, 0, 0, 3'd4, 1, 16'hFFFF, "R12 load over command");
        step(1, 4'd1, 1, 16'h0100, 16'h0200, 3'd0, 0, 0, "R4 adc after load");
        step(1, 4'd3, 1, 16'h0100, 16'h0100, 3'd0, 0, 0, "R4 sbb word");
        idle("R3 done falls");
        idle("R3 idle hold");

        while (sb.size() > 0) @(negedge clk);
        @(negedge clk);
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule